// File: doc/BRIEF.md
# Programmable Pre-Sampling Settle Timer

This block holds back the start of sampling for a programmable time after a conversion is requested. The wait gives an external amplifier or input multiplexer time to settle. A three-bit code picks one of eight settle times. The code is turned into a clock-cycle count with a `CYC_PER_US` scale factor. When the wait has run out, the block emits a one-cycle sample-start pulse.

The block also decides how the wait affects the conversion. Normally the wait simply lengthens the conversion and the averaging count passes through unchanged. When the hide control is set, the wait can instead be absorbed, and the block lowers the averaging count so that the averaging time plus the wait still fits in the nominal conversion period. Absorption needs all of the following:
- the combined two-stage filter path is selected;
- the rate is not flagged as unable to absorb;
- the period is long enough (a rate below about 2.6 kSPS);
- the wait is under half the period.

If any of these is missing, the block falls back to lengthening the conversion.

Top module: `settle_delay_top`

## Requirements
- R1: While reset is asserted, and after it is released, `samp_start_o` is 0 and `avg_adj_o` is 0 until the first start is accepted.
- R2: Delay codes 0 to 7 select settle times of 0, 4, 16, 40, 100, 200, 800 and 8000 µs. Each time is converted to cycles as µs × `CYC_PER_US`.
- R3: With code 0, `samp_start_o` rises in the cycle after `start_i` is sampled. With a nonzero code of D cycles, it rises exactly D cycles later than that.
- R4: `samp_start_o` is high for a single cycle per accepted start. It never rises without a start.
- R5: With `hide_i` = 0, the averaging count latched at start equals `avg_nom_i`.
- R6: The delay is absorbed when all of these hold:
  - `hide_i` = 1;
  - `combo_filt_i` = 1;
  - `rate_fixed_i` = 0;
  - `conv_cyc_i` > 385 × `CYC_PER_US`;
  - 2·D < `conv_cyc_i`.

  When absorbed, `avg_adj_o` = floor((`conv_cyc_i` − D) · `avg_nom_i` / `conv_cyc_i`).
- R7: If absorption is requested but any condition of R6 fails, `avg_adj_o` equals `avg_nom_i`.
- R8: A start accepted while a wait is pending restarts the wait with the new code. The pending pulse is dropped, even in the cycle where it was due.
- R9: `avg_adj_o` changes only in the cycle after an accepted start. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request, one cycle |
| dly_code_i | input | 3 | Settle-time select code |
| hide_i | input | 1 | Request to absorb the wait into the conversion |
| combo_filt_i | input | 1 | Combined two-stage filter path selected |
| rate_fixed_i | input | 1 | Current rate can never absorb a wait |
| avg_nom_i | input | AVG_W | Nominal averaging count |
| conv_cyc_i | input | PER_W | Nominal conversion period in cycles |
| samp_start_o | output | 1 | Sample-start pulse |
| avg_adj_o | output | AVG_W | Averaging count to use for this conversion |

## Verification
A new start and the expiry of a pending wait can land in the same clock cycle. The bench provokes this by launching a 16-cycle wait and issuing a second start with a 4-cycle code exactly in the cycle where the first pulse would fire. It then expects no pulse in that slot and a single pulse four cycles after the second start. A reset applied in the middle of a wait is likewise checked to leave no stray pulse behind.

// File: rtl/settle_pkg.sv
package settle_pkg;

  localparam int unsigned NUM_CODES   = 8;
  localparam int unsigned MAX_DLY_US  = 8000;
  localparam int unsigned MIN_ABS_US  = 385;

  // settle time in microseconds for each select code
  function automatic int unsigned code_to_us(input int unsigned code);
    case (code)
      0:       code_to_us = 0;
      1:       code_to_us = 4;
      2:       code_to_us = 16;
      3:       code_to_us = 40;
      4:       code_to_us = 100;
      5:       code_to_us = 200;
      6:       code_to_us = 800;
      default: code_to_us = MAX_DLY_US;
    endcase
  endfunction

endpackage

// File: rtl/settle_dly_lut.sv
module settle_dly_lut
  import settle_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 1,
  parameter int unsigned DLY_W      = 13
) (
  input  logic [2:0]       code_i,
  output logic [DLY_W-1:0] cyc_o
);

  logic [DLY_W-1:0] tbl [NUM_CODES];

  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_tbl
    assign tbl[gi] = DLY_W'(code_to_us(gi) * CYC_PER_US);
  end

  assign cyc_o = tbl[code_i];

endmodule

// File: rtl/settle_absorb.sv
module settle_absorb
  import settle_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 1,
  parameter int unsigned DLY_W      = 13,
  parameter int unsigned AVG_W      = 12,
  parameter int unsigned PER_W      = 20
) (
  input  logic [DLY_W-1:0] dly_cyc_i,
  input  logic             hide_i,
  input  logic             combo_filt_i,
  input  logic             rate_fixed_i,
  input  logic [AVG_W-1:0] avg_nom_i,
  input  logic [PER_W-1:0] conv_cyc_i,
  output logic [AVG_W-1:0] avg_adj_o
);

  localparam int unsigned PROD_W  = PER_W + AVG_W;
  localparam int unsigned MIN_CYC = MIN_ABS_US * CYC_PER_US;

  logic [PER_W:0]    dly_x2;
  logic [PER_W-1:0]  dly_ext;
  logic              slow_rate;
  logic              fits_half;
  logic              absorb;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    dly_ext   = PER_W'(dly_cyc_i);
    dly_x2    = {dly_ext, 1'b0};
    slow_rate = conv_cyc_i > PER_W'(MIN_CYC);
    fits_half = dly_x2 < {1'b0, conv_cyc_i};
    absorb    = hide_i && combo_filt_i && !rate_fixed_i && slow_rate && fits_half;
    // divisor is never zero when absorb is set (slow_rate guarantees it)
    prod      = PROD_W'(conv_cyc_i - dly_ext) * PROD_W'(avg_nom_i);
    quot      = absorb ? prod / PROD_W'(conv_cyc_i) : PROD_W'(avg_nom_i);
    avg_adj_o = AVG_W'(quot);
  end

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned DLY_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] load_i,
  output logic             fire_o
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             fire_q, fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fire_d = 1'b0;
    if (start_i) begin
      // a new start always wins over a pending expiry
      if (load_i == '0) begin
        fire_d = 1'b1;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = load_i;
      end
    end else if (busy_q) begin
      if (cnt_q == DLY_W'(1)) begin
        fire_d = 1'b1;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q - DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/settle_delay_top.sv
module settle_delay_top
  import settle_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 1,
  parameter int unsigned AVG_W      = 12,
  parameter int unsigned PER_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       dly_code_i,
  input  logic             hide_i,
  input  logic             combo_filt_i,
  input  logic             rate_fixed_i,
  input  logic [AVG_W-1:0] avg_nom_i,
  input  logic [PER_W-1:0] conv_cyc_i,
  output logic             samp_start_o,
  output logic [AVG_W-1:0] avg_adj_o
);

  localparam int unsigned DLY_W = $clog2(MAX_DLY_US * CYC_PER_US + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DLY_W-1:0] dly_cyc;
  logic [AVG_W-1:0] avg_calc;
  logic [AVG_W-1:0] avg_q, avg_d;
  logic             avg_en;

  settle_dly_lut #(.CYC_PER_US(CYC_PER_US), .DLY_W(DLY_W)) u_lut (
    .code_i (dly_code_i),
    .cyc_o  (dly_cyc)
  );

  settle_absorb #(
    .CYC_PER_US(CYC_PER_US), .DLY_W(DLY_W), .AVG_W(AVG_W), .PER_W(PER_W)
  ) u_absorb (
    .dly_cyc_i    (dly_cyc),
    .hide_i       (hide_i),
    .combo_filt_i (combo_filt_i),
    .rate_fixed_i (rate_fixed_i),
    .avg_nom_i    (avg_nom_i),
    .conv_cyc_i   (conv_cyc_i),
    .avg_adj_o    (avg_calc)
  );

  settle_timer #(.DLY_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .load_i  (dly_cyc),
    .fire_o  (samp_start_o)
  );

  assign avg_en = start_i;

  always_comb begin
    avg_d = avg_q;
    if (avg_en) avg_d = avg_calc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) avg_q <= '0;
    else            avg_q <= avg_d;
  end

  assign avg_adj_o = avg_q;

endmodule

// File: rtl/settle_delay_chk.sv
module settle_delay_chk #(
  parameter int unsigned AVG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [2:0]       dly_code_i,
  input logic             hide_i,
  input logic [AVG_W-1:0] avg_nom_i,
  input logic             samp_start_o,
  input logic [AVG_W-1:0] avg_adj_o
);

  p_zero_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && dly_code_i == 3'd0) |=> samp_start_o);

  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && dly_code_i != 3'd0) |=> !samp_start_o);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_start_o && !start_i) |=> !samp_start_o);

  p_pass_avg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !hide_i) |=> (avg_adj_o == $past(avg_nom_i)));

  p_avg_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (avg_adj_o <= $past(avg_nom_i)));

  p_avg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(avg_adj_o));

endmodule

bind settle_delay_top settle_delay_chk #(.AVG_W(AVG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .dly_code_i   (dly_code_i),
  .hide_i       (hide_i),
  .avg_nom_i    (avg_nom_i),
  .samp_start_o (samp_start_o),
  .avg_adj_o    (avg_adj_o)
);

// File: tb/settle_delay_top_tb_top.sv
`timescale 1ns/1ps
module settle_delay_top_tb_top;

  localparam int AVG_W = 12;
  localparam int PER_W = 20;
  localparam int NV    = 12;

  // code, hide, combo, fixed, avg, conv, expected latency, expected avg
  localparam int V_CODE [NV] = '{0, 1, 2, 4, 5, 5, 3, 3, 3, 6, 7, 7};
  localparam int V_HIDE [NV] = '{1, 0, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int V_CMB  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1};
  localparam int V_FIX  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam int V_AVG  [NV] = '{100, 100, 100, 50, 64, 64, 80, 80, 80, 200, 10, 10};
  localparam int V_CONV [NV] = '{1000, 1000, 1000, 1000, 400, 401, 380, 1000, 1000, 5000, 20000, 20000};
  localparam int V_LAT  [NV] = '{0, 4, 16, 100, 200, 200, 40, 40, 40, 800, 8000, 8000};
  localparam int V_EAVG [NV] = '{100, 100, 98, 45, 64, 32, 80, 80, 80, 168, 10, 6};

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [2:0]       dly_code_i;
  logic             hide_i;
  logic             combo_filt_i;
  logic             rate_fixed_i;
  logic [AVG_W-1:0] avg_nom_i;
  logic [PER_W-1:0] conv_cyc_i;
  logic             samp_start_o;
  logic [AVG_W-1:0] avg_adj_o;

  int n_chk;
  int n_bad;

  settle_delay_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dly_code_i   (dly_code_i),
    .hide_i       (hide_i),
    .combo_filt_i (combo_filt_i),
    .rate_fixed_i (rate_fixed_i),
    .avg_nom_i    (avg_nom_i),
    .conv_cyc_i   (conv_cyc_i),
    .samp_start_o (samp_start_o),
    .avg_adj_o    (avg_adj_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_in(input int code, input int hide, input int cmb,
                        input int fix, input int avg, input int conv);
    dly_code_i   = 3'(code);
    hide_i       = hide[0];
    combo_filt_i = cmb[0];
    rate_fixed_i = fix[0];
    avg_nom_i    = AVG_W'(avg);
    conv_cyc_i   = PER_W'(conv);
  endtask

  // issue a start at a negedge; returns cycles until the pulse is seen
  task automatic launch_and_wait(output int lat);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!samp_start_o && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    set_in(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 reset pulse", samp_start_o, 0);
    check("R1 reset avg", avg_adj_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release avg", avg_adj_o, 0);
    check("R4 no pulse idle", samp_start_o, 0);

    // vector table: R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      set_in(V_CODE[i], V_HIDE[i], V_CMB[i], V_FIX[i], V_AVG[i], V_CONV[i]);
      @(negedge clk);
      launch_and_wait(lat);
      check($sformatf("R2/R3 latency vec%0d", i), lat, V_LAT[i]);
      check($sformatf("R5/R6/R7 avg vec%0d", i), avg_adj_o, V_EAVG[i]);
      @(negedge clk);
      check($sformatf("R4 pulse width vec%0d", i), samp_start_o, 0);
    end

    // R9: avg holds while inputs move without a start
    set_in(3, 0, 0, 0, 777, 900);
    repeat (6) @(negedge clk);
    check("R9 avg held", avg_adj_o, 6);

    // R8: restart lands in the cycle where the 16-cycle wait would fire
    set_in(2, 0, 1, 0, 33, 1000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (15) @(negedge clk);
    set_in(1, 0, 1, 0, 44, 1000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R8 pending pulse dropped", samp_start_o, 0);
    check("R8 new avg latched", avg_adj_o, 44);
    lat = 0;
    while (!samp_start_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R8 restart latency", lat, 4);
    @(negedge clk);
    check("R8 single pulse", samp_start_o, 0);

    // R1/R4: reset in the middle of a wait leaves no pulse
    set_in(4, 0, 1, 0, 20, 1000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-wait reset pulse", samp_start_o, 0);
    check("R1 mid-wait reset avg", avg_adj_o, 0);
    rst_n = 1'b1;
    lat = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (samp_start_o) lat++;
    end
    check("R4 no stray pulse after reset", lat, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule